// File: doc/BRIEF.md
# Handshake Byte Transfer Controller

This block moves packet bytes between a host processor and a small on-chip controller. The host shares an 8-bit shift byte with the block and drives two active-low strobes: `tip_n` frames a transfer and `ack_n` paces it. The block drives one active-low request line back to the host and raises a delayed interrupt for every handshake step. A separate direction input selects which way the bytes flow.

In the host-to-device direction, every change of the strobe pair while `tip_n` is low captures the shift byte into an outbound store. When `tip_n` rises again, a packet-done pulse reports how many bytes were captured. In the device-to-host direction, the packet side first fills an inbound store and loads a length. The block then asks the host to read with `req_n`, presents one stored byte per strobe change, and releases the request after the last byte. While no transfer is framed, the request line follows `ack_n` so the two sides can resynchronise.

Top module: `hs_xfer_ctrl`

## Requirements
- R1: After reset `req_n` is 1, `sr_irq` and `pkt_done` are 0, `sr_rd_byte` is 0, and no interrupt is pending.
- R2: While `tip_n`=0 and `dir_h2d`=1, each cycle in which {`tip_n`,`ack_n`} differs from its value in the previous cycle stores `sr_wr_byte` in the next outbound slot, starting at slot 0. Slot i is readable on `ob_rdata` when `ob_raddr`=i.
- R3: While `tip_n`=0 and `dir_h2d`=0, each change of the strobe pair, while loaded bytes remain, presents the next inbound byte on `sr_rd_byte`, in slot order from slot 0, at the clock edge that samples the change.
- R4: The edge that presents the last loaded inbound byte also drives `req_n` to 1.
- R5: While `tip_n` stays 1 for two consecutive samples and `ack_n` changes, `req_n` takes the new `ack_n` level at the next edge and an interrupt is started.
- R6: When `tip_n` goes from 0 to 1, an interrupt is always started. If at least one byte was captured, `pkt_done` pulses for one cycle with `pkt_len` equal to the count. The count is then cleared, so the next packet starts again at slot 0.
- R7: While `tip_n`=1 and unread inbound bytes remain, `req_n` is driven to 0. This happens on the second edge after the load when no transfer is framed.
- R8: Outbound bytes that arrive when all DEPTH slots are full are dropped: they start no interrupt, the stored slots keep their values, and `pkt_len` saturates at DEPTH.
- R9: `sr_irq` is high for exactly one cycle, on the TICKS-th clock edge after the edge that samples the triggering event. TICKS = (CLK_HZ/1000)·DELAY_US/1000, with a minimum of 1.
- R10: A new triggering event while the delay is counting restarts it, so the earlier event produces no interrupt of its own.
- R11: Strobe changes in the device-to-host direction after all loaded bytes are consumed leave `sr_rd_byte` unchanged and start no interrupt.
- R12: A one-cycle `ib_load` sets the inbound length to `ib_len`, clamped to DEPTH, and restarts reading at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tip_n | input | 1 | Host transfer framing strobe, active low |
| ack_n | input | 1 | Host byte pacing strobe, active low |
| dir_h2d | input | 1 | 1: host-to-device, 0: device-to-host |
| sr_wr_byte | input | 8 | Shift byte written by the host |
| sr_rd_byte | output | 8 | Shift byte presented to the host |
| req_n | output | 1 | Request to the host, active low |
| sr_irq | output | 1 | Delayed shift interrupt pulse |
| pkt_done | output | 1 | One-cycle pulse when a non-empty outbound packet ends |
| pkt_len | output | IW | Byte count of the last outbound packet |
| ob_raddr | input | AW | Outbound slot read address |
| ob_rdata | output | 8 | Outbound slot contents |
| ib_we | input | 1 | Inbound slot write enable |
| ib_waddr | input | AW | Inbound slot write address |
| ib_wdata | input | 8 | Inbound slot write data |
| ib_load | input | 1 | Load inbound length and restart reading |
| ib_len | input | IW | Inbound packet length |

## Verification
The hardest conditions to reach are the overflow drop and the restarted delay, because both show up only as an interrupt that does not appear. The stimulus sweeps the outbound packet length from zero to two past a four-slot configuration. For each dropped byte, the bench confirms the interrupt stays quiet for the whole delay window and that the stored slots survive. For the restart case, a second strobe edge is placed three cycles after the first, and the bench checks that nothing fires at the first edge's due time.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;

    typedef struct packed {
        logic tip_n;
        logic ack_n;
    } hs_pair_t;

    function automatic int delay_ticks(input longint clk_hz, input int delay_us);
        longint t;
        t = ((clk_hz / 1000) * longint'(delay_us)) / 1000;
        if (t < 1) t = 1;
        return int'(t);
    endfunction

endpackage

// File: rtl/hs_byte_store.sv
module hs_byte_store #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SLOTS = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] slot_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) slot_q[i] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/hs_delay_timer.sv
module hs_delay_timer #(
    parameter int TICKS = 2500,
    localparam int CW = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic irq
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          irq_d, irq_q;

    always_comb begin
        cnt_d = cnt_q;
        irq_d = 1'b0;
        if (start) begin
            cnt_d = CW'(TICKS);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
            irq_d = (cnt_q == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R9
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !irq_q); // R10

endmodule

// File: rtl/hs_xfer_ctrl.sv
module hs_xfer_ctrl
    import hs_xfer_pkg::*;
#(
    parameter int     DEPTH    = 16,
    parameter longint CLK_HZ   = 125_000_000,
    parameter int     DELAY_US = 20,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tip_n,
    input  logic          ack_n,
    input  logic          dir_h2d,
    input  logic [7:0]    sr_wr_byte,
    output logic [7:0]    sr_rd_byte,
    output logic          req_n,
    output logic          sr_irq,
    output logic          pkt_done,
    output logic [IW-1:0] pkt_len,
    input  logic [AW-1:0] ob_raddr,
    output logic [7:0]    ob_rdata,
    input  logic          ib_we,
    input  logic [AW-1:0] ib_waddr,
    input  logic [7:0]    ib_wdata,
    input  logic          ib_load,
    input  logic [IW-1:0] ib_len
);

    localparam int            TICKS = delay_ticks(CLK_HZ, DELAY_US);
    localparam logic [IW-1:0] FULL  = IW'(DEPTH);

    typedef struct packed {
        hs_pair_t      last;
        logic [IW-1:0] out_idx;
        logic [IW-1:0] in_idx;
        logic [IW-1:0] in_len;
        logic          req_n;
        logic [7:0]    sr_out;
        logic          pkt_done;
        logic [IW-1:0] pkt_len;
    } st_t;

    st_t           st_d, st_q;
    hs_pair_t      now;
    logic          pair_chg;
    logic          ob_we;
    logic          irq_start;
    logic [7:0]    ib_rdata;
    logic [IW-1:0] in_idx_nx;

    assign now      = '{tip_n: tip_n, ack_n: ack_n};
    assign pair_chg = (now != st_q.last);

    hs_byte_store #(.DEPTH(DEPTH)) u_out_store (
        .clk   (clk),
        .we    (ob_we),
        .waddr (st_q.out_idx[AW-1:0]),
        .wdata (sr_wr_byte),
        .raddr (ob_raddr),
        .rdata (ob_rdata)
    );

    hs_byte_store #(.DEPTH(DEPTH)) u_in_store (
        .clk   (clk),
        .we    (ib_we),
        .waddr (ib_waddr),
        .wdata (ib_wdata),
        .raddr (st_q.in_idx[AW-1:0]),
        .rdata (ib_rdata)
    );

    hs_delay_timer #(.TICKS(TICKS)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .start (irq_start),
        .irq   (sr_irq)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pkt_done = 1'b0;
        ob_we         = 1'b0;
        irq_start     = 1'b0;
        in_idx_nx     = st_q.in_idx + 1'b1;

        if (!tip_n) begin
            if (dir_h2d) begin
                if (pair_chg && (st_q.out_idx < FULL)) begin
                    ob_we        = 1'b1;
                    st_d.out_idx = st_q.out_idx + 1'b1;
                    irq_start    = 1'b1;
                end
            end else if (pair_chg && (st_q.in_idx < st_q.in_len)) begin
                st_d.sr_out = ib_rdata;
                st_d.in_idx = in_idx_nx;
                if (in_idx_nx >= st_q.in_len) st_d.req_n = 1'b1;
                irq_start   = 1'b1;
            end
        end else if (st_q.last.tip_n && (ack_n != st_q.last.ack_n)) begin
            st_d.req_n = ack_n;
            irq_start  = 1'b1;
        end else begin
            if (!st_q.last.tip_n) begin
                irq_start = 1'b1;
                if (st_q.out_idx != '0) begin
                    st_d.pkt_done = 1'b1;
                    st_d.pkt_len  = st_q.out_idx;
                end
                st_d.out_idx = '0;
            end
            if (st_q.in_idx < st_q.in_len) st_d.req_n = 1'b0;
        end

        if (ib_load) begin
            st_d.in_len = (ib_len > FULL) ? FULL : ib_len;
            st_d.in_idx = '0;
        end

        st_d.last = now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.last     <= '{tip_n: 1'b1, ack_n: 1'b1};
            st_q.req_n    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_rd_byte = st_q.sr_out;
    assign req_n      = st_q.req_n;
    assign pkt_done   = st_q.pkt_done;
    assign pkt_len    = st_q.pkt_len;

    AST_PKT_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (st_q.last.tip_n && !$past(st_q.last.tip_n))); // R6
    AST_PKT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len != '0)); // R6
    AST_SYNC_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (tip_n && st_q.last.tip_n && (ack_n != st_q.last.ack_n))
        |=> (req_n == $past(ack_n))); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!tip_n && dir_h2d && (st_q.out_idx == FULL)) |=> (st_q.out_idx == FULL)); // R8
    AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!tip_n && !dir_h2d && pair_chg && !ib_load
         && (st_q.in_idx < st_q.in_len) && (in_idx_nx == st_q.in_len)) |=> req_n); // R4

endmodule

// File: tb/sim_hs_xfer_ctrl.sv
module sim_hs_xfer_ctrl;

    localparam int     DEPTH = 4;
    localparam longint HZ    = 400_000;
    localparam int     DUS   = 20;
    localparam int     T     = int'((HZ / 1000) * DUS / 1000);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tip_n = 1'b1, ack_n = 1'b1, dir_h2d = 1'b1;
    logic [7:0] sr_wr_byte = '0;
    logic [7:0] sr_rd_byte;
    logic       req_n, sr_irq, pkt_done;
    logic [2:0] pkt_len;
    logic [1:0] ob_raddr = '0;
    logic [7:0] ob_rdata;
    logic       ib_we = 1'b0;
    logic [1:0] ib_waddr = '0;
    logic [7:0] ib_wdata = '0;
    logic       ib_load = 1'b0;
    logic [2:0] ib_len = '0;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    hs_xfer_ctrl #(.DEPTH(DEPTH), .CLK_HZ(HZ), .DELAY_US(DUS)) u0 (
        .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n), .dir_h2d(dir_h2d),
        .sr_wr_byte(sr_wr_byte), .sr_rd_byte(sr_rd_byte), .req_n(req_n),
        .sr_irq(sr_irq), .pkt_done(pkt_done), .pkt_len(pkt_len),
        .ob_raddr(ob_raddr), .ob_rdata(ob_rdata), .ib_we(ib_we), .ib_waddr(ib_waddr),
        .ib_wdata(ib_wdata), .ib_load(ib_load), .ib_len(ib_len)
    );

    function automatic logic [7:0] hv(input int n, input int k);
        return 8'((n * 37 + k * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] dv(input int n, input int k);
        return 8'((n * 53 + k * 29 + 3) & 255);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(input logic t, input logic a);
        tip_n = t;
        ack_n = a;
        @(negedge clk);
    endtask

    task automatic wait_irq(input logic exp, input string tag);
        int early = 0;
        for (int k = 2; k <= T; k++) begin
            @(negedge clk);
            if (sr_irq) early++;
        end
        chk({tag, " early irq"}, early, 0);
        @(negedge clk);
        chk({tag, " irq at delay"}, int'(sr_irq), int'(exp));
        @(negedge clk);
        chk({tag, " irq one cycle"}, int'(sr_irq), 0);
    endtask

    task automatic h2d(input int n);
        logic a = 1'b1;
        int   m = (n > DEPTH) ? DEPTH : n;
        if (n == 0) begin
            dir_h2d = 1'b0;
            step(1'b0, 1'b1);
            wait_irq(1'b0, "R6 empty frame no step");
            step(1'b1, 1'b1);
            chk("R6 empty frame no pkt_done", int'(pkt_done), 0);
            wait_irq(1'b1, "R6 empty frame end");
            return;
        end
        dir_h2d    = 1'b1;
        sr_wr_byte = hv(n, 0);
        step(1'b0, 1'b1);
        wait_irq(1'b1, "R2 R9 first byte");
        for (int k = 1; k < n; k++) begin
            sr_wr_byte = hv(n, k);
            a = ~a;
            step(1'b0, a);
            wait_irq(k < DEPTH, (k < DEPTH) ? "R2 R9 byte" : "R8 dropped byte");
        end
        step(1'b1, a);
        chk("R6 pkt_done", int'(pkt_done), 1);
        chk("R6 R8 pkt_len", int'(pkt_len), m);
        wait_irq(1'b1, "R6 end irq");
        if (!a) begin
            step(1'b1, 1'b1);
            chk("R5 req_n follows ack", int'(req_n), 1);
            wait_irq(1'b1, "R5 sync irq");
        end
        for (int i = 0; i < m; i++) begin
            ob_raddr = 2'(i);
            #1;
            chk("R2 R8 stored slot", int'(ob_rdata), int'(hv(n, i)));
        end
    endtask

    task automatic d2h(input int n);
        logic a = 1'b1;
        int   m = (n > DEPTH) ? DEPTH : n;
        for (int k = 0; k < m; k++) begin
            ib_we    = 1'b1;
            ib_waddr = 2'(k);
            ib_wdata = dv(n, k);
            @(negedge clk);
        end
        ib_we   = 1'b0;
        ib_len  = 3'(n);
        ib_load = 1'b1;
        @(negedge clk);
        ib_load = 1'b0;
        chk("R7 req_n not yet low", int'(req_n), 1);
        @(negedge clk);
        chk("R7 req_n low with data", int'(req_n), 0);
        dir_h2d = 1'b0;
        step(1'b0, 1'b1);
        chk("R3 R12 first byte", int'(sr_rd_byte), int'(dv(n, 0)));
        chk("R4 req_n after first", int'(req_n), (m == 1) ? 1 : 0);
        wait_irq(1'b1, "R9 d2h first");
        for (int k = 1; k < m; k++) begin
            a = ~a;
            step(1'b0, a);
            chk("R3 next byte", int'(sr_rd_byte), int'(dv(n, k)));
            chk("R4 req_n release", int'(req_n), (k == m - 1) ? 1 : 0);
            wait_irq(1'b1, "R9 d2h byte");
        end
        a = ~a;
        step(1'b0, a);
        chk("R11 byte unchanged", int'(sr_rd_byte), int'(dv(n, m - 1)));
        wait_irq(1'b0, "R11 no irq");
        step(1'b1, a);
        chk("R6 no pkt_done on read", int'(pkt_done), 0);
        chk("R7 req_n stays high", int'(req_n), 1);
        wait_irq(1'b1, "R6 d2h end irq");
        if (!a) begin
            step(1'b1, 1'b1);
            wait_irq(1'b1, "R5 sync irq");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_n", int'(req_n), 1);
        chk("R1 sr_irq", int'(sr_irq), 0);
        chk("R1 pkt_done", int'(pkt_done), 0);
        chk("R1 sr_rd_byte", int'(sr_rd_byte), 0);
        wait_irq(1'b0, "R1 nothing pending");

        // R5: sync phase, request mirrors ack
        step(1'b1, 1'b0);
        chk("R5 req_n low", int'(req_n), 0);
        wait_irq(1'b1, "R5 irq");
        step(1'b1, 1'b1);
        chk("R5 req_n high", int'(req_n), 1);
        wait_irq(1'b1, "R5 irq back");

        for (int n = 0; n <= DEPTH + 2; n++) h2d(n);

        // R10: second edge inside the window restarts the delay
        dir_h2d    = 1'b1;
        sr_wr_byte = 8'hA5;
        step(1'b0, 1'b1);
        @(negedge clk);
        chk("R10 quiet", int'(sr_irq), 0);
        @(negedge clk);
        sr_wr_byte = 8'h5A;
        step(1'b0, 1'b0);
        wait_irq(1'b1, "R10 restarted");
        step(1'b1, 1'b0);
        chk("R10 pkt_len", int'(pkt_len), 2);
        wait_irq(1'b1, "R6 end");
        step(1'b1, 1'b1);
        wait_irq(1'b1, "R5 sync");
        ob_raddr = 2'd1;
        #1;
        chk("R2 second slot", int'(ob_rdata), 8'h5A);

        for (int n = 1; n <= DEPTH; n++) d2h(n);
        d2h(6);   // R12: length clamped to DEPTH

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule